// File: doc/BRIEF.md
# Upstream Read Request Splitter

This block sits between a 128-bit memory-mapped slave port and the request path of a PCI Express transaction layer. It accepts a read burst of up to 32 beats (512 bytes), checks the byte enables, and cuts the burst into read request descriptors. Each descriptor holds a byte address, a length in dwords, byte enables for the first and last dword, and a flag that selects the 64-bit address format. No descriptor is longer than 256 bytes, and none runs past a 4 KB address boundary.

The block keeps a count of issued descriptors that have not yet completed. Each pulse on the completion-done input frees one slot. When all slots are in use, the slave port is stalled, and a burst that is part way through splitting waits until a slot is freed. A request with an illegal burst count or illegal byte enables never hangs the port. It is answered with a one-cycle error pulse.

Top module: `rd_req_splitter`

## Requirements
- R1: While reset is held and after it is released, `req_wait_o`, `dsc_valid_o` and `req_err_o` are low.
- R2: Every descriptor has a non-zero length of at most 64 dwords (256 bytes).
- R3: A burst whose beat address is A (the low four bits are cleared) and whose size is B bytes is issued as descriptors at ascending addresses that cover A to A+B-1 exactly. Each descriptor length is the minimum of three values: the bytes remaining, the bytes up to the next 4 KB boundary, and 256. No descriptor crosses a 4 KB boundary. Descriptors from a multi-beat burst carry first and last byte enables of 4'hF.
- R4: A request is taken on a rising edge where `req_valid_i` is high and `req_wait_o` is low. After a legal request is taken, `req_wait_o` is high from the next cycle until the last descriptor of that request has been loaded into the output register.
- R5: Each loaded descriptor takes one of eight slots, and each `cpl_done_i` pulse frees one. `cpl_done_i` has no effect when no slot is taken. With eight slots taken, `req_wait_o` is high and no further descriptor is issued, even in the middle of a burst, until a completion frees a slot.
- R6: A request with a burst count greater than one is legal only when all 16 byte-enable bits are set.
- R7: A single-beat request splits its byte enables into nibble i = bits [4i+3:4i], which covers dword i at byte offset 4i. The request is legal only if at least one nibble is non-zero and every nibble strictly between the lowest and the highest non-zero nibble is 4'hF.
- R8: A legal single-beat request gives one descriptor. Its address is the beat address plus 4 times the index of the lowest enabled dword. Its length is the span from the lowest to the highest enabled dword. Its first byte enable is the lowest enabled nibble. Its last byte enable is the highest enabled nibble, or 4'h0 when the span is one dword.
- R9: `dsc_fmt64_o` is high exactly when bits [63:32] of the descriptor address are non-zero.
- R10: An illegal request, which includes a burst count of 0 or above 32, raises `req_err_o` for one cycle in the cycle after it is taken. It issues no descriptor, takes no slot, and leaves `req_wait_o` low.
- R11: While `dsc_valid_o` is high and `dsc_ready_i` is low, the descriptor fields hold steady.
- R12: Address bits [3:0] of a request have no effect on any descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_addr_i | input | 64 | Byte address of the first beat |
| req_burst_i | input | 6 | Burst count in 16-byte beats |
| req_be_i | input | 16 | Byte enables |
| req_wait_o | output | 1 | Stall for the slave port |
| req_err_o | output | 1 | Abort pulse for an illegal request |
| dsc_valid_o | output | 1 | Descriptor valid |
| dsc_ready_i | input | 1 | Descriptor accepted by the consumer |
| dsc_addr_o | output | 64 | Descriptor byte address |
| dsc_len_o | output | 7 | Descriptor length in dwords |
| dsc_first_be_o | output | 4 | First-dword byte enables |
| dsc_last_be_o | output | 4 | Last-dword byte enables |
| dsc_fmt64_o | output | 1 | 64-bit address format flag |
| cpl_done_i | input | 1 | Completion done; frees one slot |

## Verification
Take E as the rising edge that accepts a request. `req_err_o` and the raised `req_wait_o` are visible in the half cycle after E. The first descriptor is loaded on the following edge. When the consumer is ready and a slot is free, each later chunk follows one edge after the one before it. The bench drives inputs on falling edges and samples outputs on falling edges. After each request it first checks the error and stall state. It then polls for each expected descriptor one falling edge at a time, and after the last one it confirms that no extra descriptor appears. A completion pulse takes effect on the edge after it is raised. The slot-limit checks therefore wait one more edge for a stalled chunk before they expect it.

// File: rtl/rd_split_pkg.sv
package rd_split_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_SPLIT} split_st_e;
  localparam int unsigned BEAT_BYTES = 16;
  localparam int unsigned BEAT_LSB   = 4;
endpackage

// File: rtl/rd_be_check.sv
module rd_be_check #(
  parameter int unsigned BE_W     = 16,
  parameter int unsigned DW_IDX_W = 2,
  parameter int unsigned DW_CNT_W = 3
) (
  input  logic [BE_W-1:0]     be_i,
  output logic                legal_o,
  output logic [DW_IDX_W-1:0] first_dw_o,
  output logic [DW_CNT_W-1:0] span_o,
  output logic [3:0]          first_be_o,
  output logic [3:0]          last_be_o
);
  localparam int unsigned NUM_DW = BE_W / 4;

  logic [NUM_DW-1:0] dw_en, dw_full;
  logic [DW_IDX_W-1:0] lo, hi;
  logic found, ok;

  for (genvar g = 0; g < NUM_DW; g++) begin : g_dw
    assign dw_en[g]   = |be_i[4*g +: 4];
    assign dw_full[g] = &be_i[4*g +: 4];
  end

  always_comb begin
    lo    = '0;
    hi    = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_DW; i++) begin
      if (dw_en[i] && !found) begin
        lo    = DW_IDX_W'(i);
        found = 1'b1;
      end
      if (dw_en[i]) hi = DW_IDX_W'(i);
    end
    ok = found;
    // interior dwords must be fully enabled (implies contiguity)
    for (int i = 0; i < NUM_DW; i++) begin
      if (i > int'(lo) && i < int'(hi) && !dw_full[i]) ok = 1'b0;
    end
  end

  assign legal_o    = ok;
  assign first_dw_o = lo;
  assign span_o     = DW_CNT_W'(hi) - DW_CNT_W'(lo) + DW_CNT_W'(1);
  assign first_be_o = be_i[{lo, 2'b00} +: 4];
  assign last_be_o  = (hi == lo) ? 4'h0 : be_i[{hi, 2'b00} +: 4];
endmodule

// File: rtl/rd_chunk_calc.sv
module rd_chunk_calc #(
  parameter int unsigned MAX_RD_BYTES = 256,
  parameter int unsigned BOUNDARY     = 4096,
  parameter int unsigned REM_W        = 10,
  parameter int unsigned OFF_W        = 12
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [REM_W-1:0] rem_i,
  output logic [REM_W-1:0] chunk_o
);
  localparam int unsigned CW = ((REM_W > OFF_W) ? REM_W : OFF_W) + 2;

  logic [CW-1:0] rem_w, bnd_w, cap_w, m1, m2;

  assign rem_w   = CW'(rem_i);
  assign bnd_w   = CW'(BOUNDARY) - CW'(off_i);
  assign cap_w   = CW'(MAX_RD_BYTES);
  assign m1      = (rem_w < bnd_w) ? rem_w : bnd_w;
  assign m2      = (m1 < cap_w) ? m1 : cap_w;
  assign chunk_o = REM_W'(m2);
endmodule

// File: rtl/rd_out_cnt.sv
module rd_out_cnt #(
  parameter int unsigned MAX_OUTST = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic full_o
);
  localparam int unsigned CNT_W = $clog2(MAX_OUTST + 1);

  logic [CNT_W-1:0] cnt_q;
  logic dec_ok;

  assign dec_ok = dec_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (inc_i && !dec_ok)  cnt_q <= cnt_q + CNT_W'(1);
    else if (!inc_i && dec_ok)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign full_o = (cnt_q == CNT_W'(MAX_OUTST));
endmodule

// File: rtl/rd_req_splitter.sv
module rd_req_splitter
  import rd_split_pkg::*;
#(
  parameter int unsigned ADDR_W       = 64,
  parameter int unsigned MAX_BURST    = 32,
  parameter int unsigned MAX_RD_BYTES = 256,
  parameter int unsigned BOUNDARY     = 4096,
  parameter int unsigned MAX_OUTST    = 8,
  localparam int unsigned BC_W        = $clog2(MAX_BURST + 1),
  localparam int unsigned LEN_W       = $clog2(MAX_RD_BYTES / 4 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BC_W-1:0]   req_burst_i,
  input  logic [15:0]       req_be_i,
  output logic              req_wait_o,
  output logic              req_err_o,
  output logic              dsc_valid_o,
  input  logic              dsc_ready_i,
  output logic [ADDR_W-1:0] dsc_addr_o,
  output logic [LEN_W-1:0]  dsc_len_o,
  output logic [3:0]        dsc_first_be_o,
  output logic [3:0]        dsc_last_be_o,
  output logic              dsc_fmt64_o,
  input  logic              cpl_done_i
);
  localparam int unsigned REM_W    = $clog2(MAX_BURST * BEAT_BYTES + 1);
  localparam int unsigned OFF_W    = $clog2(BOUNDARY);
  localparam int unsigned DW_IDX_W = $clog2(BEAT_BYTES / 4);
  localparam int unsigned DW_CNT_W = $clog2(BEAT_BYTES / 4 + 1);

  split_st_e         st_q;
  logic [ADDR_W-1:0] cur_addr_q, beat_addr;
  logic [REM_W-1:0]  rem_q, chunk;
  logic              single_q, err_q;
  logic [LEN_W-1:0]  sb_len_q, ld_len;
  logic [3:0]        sb_fbe_q, sb_lbe_q, ld_fbe, ld_lbe;
  logic              cnt_full, accept, load, last_ld, fmt_nx;
  logic              bc_ok, is_single, req_legal;
  logic              sb_legal;
  logic [DW_IDX_W-1:0] sb_first_dw;
  logic [DW_CNT_W-1:0] sb_span;
  logic [3:0]        sb_fbe, sb_lbe;

  rd_be_check #(.BE_W(BEAT_BYTES), .DW_IDX_W(DW_IDX_W), .DW_CNT_W(DW_CNT_W)) u_be (
    .be_i       (req_be_i),
    .legal_o    (sb_legal),
    .first_dw_o (sb_first_dw),
    .span_o     (sb_span),
    .first_be_o (sb_fbe),
    .last_be_o  (sb_lbe)
  );

  rd_chunk_calc #(.MAX_RD_BYTES(MAX_RD_BYTES), .BOUNDARY(BOUNDARY),
                  .REM_W(REM_W), .OFF_W(OFF_W)) u_chunk (
    .off_i   (cur_addr_q[OFF_W-1:0]),
    .rem_i   (rem_q),
    .chunk_o (chunk)
  );

  rd_out_cnt #(.MAX_OUTST(MAX_OUTST)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (load),
    .dec_i  (cpl_done_i),
    .full_o (cnt_full)
  );

  assign req_wait_o = (st_q != ST_IDLE) || cnt_full;
  assign accept     = req_valid_i && !req_wait_o;
  assign is_single  = (req_burst_i == BC_W'(1));
  assign bc_ok      = (req_burst_i != '0) && (req_burst_i <= BC_W'(MAX_BURST));
  assign req_legal  = bc_ok && (is_single ? sb_legal : (req_be_i == 16'hFFFF));
  assign beat_addr  = {req_addr_i[ADDR_W-1:BEAT_LSB], {BEAT_LSB{1'b0}}};

  assign load    = (st_q == ST_SPLIT) && (!dsc_valid_o || dsc_ready_i) && !cnt_full;
  assign last_ld = single_q || (rem_q == chunk);
  assign ld_len  = single_q ? sb_len_q : LEN_W'(chunk >> 2);
  assign ld_fbe  = single_q ? sb_fbe_q : 4'hF;
  assign ld_lbe  = single_q ? sb_lbe_q : 4'hF;

  if (ADDR_W > 32) begin : g_fmt_wide
    assign fmt_nx = |cur_addr_q[ADDR_W-1:32];
  end else begin : g_fmt_narrow
    assign fmt_nx = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cur_addr_q <= '0;
      rem_q      <= '0;
      single_q   <= 1'b0;
      sb_len_q   <= '0;
      sb_fbe_q   <= '0;
      sb_lbe_q   <= '0;
      err_q      <= 1'b0;
    end else begin
      err_q <= accept && !req_legal;
      if (accept && req_legal) begin
        st_q     <= ST_SPLIT;
        single_q <= is_single;
        sb_len_q <= LEN_W'(sb_span);
        sb_fbe_q <= sb_fbe;
        sb_lbe_q <= sb_lbe;
        rem_q    <= REM_W'({req_burst_i, {BEAT_LSB{1'b0}}});
        cur_addr_q <= is_single ? beat_addr + ADDR_W'({sb_first_dw, 2'b00}) : beat_addr;
      end else if (load) begin
        cur_addr_q <= cur_addr_q + ADDR_W'(chunk);
        rem_q      <= rem_q - chunk;
        if (last_ld) st_q <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dsc_valid_o    <= 1'b0;
      dsc_addr_o     <= '0;
      dsc_len_o      <= '0;
      dsc_first_be_o <= '0;
      dsc_last_be_o  <= '0;
      dsc_fmt64_o    <= 1'b0;
    end else if (load) begin
      dsc_valid_o    <= 1'b1;
      dsc_addr_o     <= cur_addr_q;
      dsc_len_o      <= ld_len;
      dsc_first_be_o <= ld_fbe;
      dsc_last_be_o  <= ld_lbe;
      dsc_fmt64_o    <= fmt_nx;
    end else if (dsc_ready_i) begin
      dsc_valid_o    <= 1'b0;
    end
  end

  assign req_err_o = err_q;
endmodule

// File: rtl/rd_req_splitter_chk.sv
module rd_req_splitter_chk #(
  parameter int unsigned ADDR_W       = 64,
  parameter int unsigned MAX_BURST    = 32,
  parameter int unsigned MAX_RD_BYTES = 256,
  parameter int unsigned BOUNDARY     = 4096,
  parameter int unsigned MAX_OUTST    = 8,
  localparam int unsigned BC_W        = $clog2(MAX_BURST + 1),
  localparam int unsigned LEN_W       = $clog2(MAX_RD_BYTES / 4 + 1),
  localparam int unsigned OFF_W       = $clog2(BOUNDARY)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [BC_W-1:0]   req_burst_i,
  input logic [15:0]       req_be_i,
  input logic              req_wait_o,
  input logic              req_err_o,
  input logic              dsc_valid_o,
  input logic              dsc_ready_i,
  input logic [ADDR_W-1:0] dsc_addr_o,
  input logic [LEN_W-1:0]  dsc_len_o,
  input logic [3:0]        dsc_first_be_o,
  input logic [3:0]        dsc_last_be_o,
  input logic              dsc_fmt64_o,
  input logic              cpl_done_i
);
  AST_LEN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsc_valid_o |-> (dsc_len_o != '0) && (int'(dsc_len_o) <= int'(MAX_RD_BYTES / 4))); // R2

  AST_NO_4K_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsc_valid_o |-> (int'(dsc_addr_o[OFF_W-1:0]) + 4 * int'(dsc_len_o) <= int'(BOUNDARY))); // R3

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_wait_o) |=> (req_wait_o || req_err_o)); // R4

  AST_LAST_BE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsc_valid_o |-> (((dsc_len_o == LEN_W'(1)) == (dsc_last_be_o == 4'h0)) && (dsc_first_be_o != 4'h0))); // R8

  AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |-> $past(req_valid_i && !req_wait_o)); // R10

  AST_DSC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsc_valid_o && !dsc_ready_i) |=> dsc_valid_o && $stable(dsc_addr_o) && $stable(dsc_len_o)
      && $stable(dsc_first_be_o) && $stable(dsc_last_be_o)); // R11
endmodule

bind rd_req_splitter rd_req_splitter_chk #(
  .ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST), .MAX_RD_BYTES(MAX_RD_BYTES),
  .BOUNDARY(BOUNDARY), .MAX_OUTST(MAX_OUTST)
) u_chk (.*);

// File: tb/tb_rd_req_splitter.sv
module tb_rd_req_splitter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic [5:0]  req_burst = '0;
  logic [15:0] req_be = '0;
  logic        req_wait, req_err, dsc_valid, dsc_fmt64;
  logic        dsc_ready = 1'b1;
  logic        cpl_done = 1'b0;
  logic [63:0] dsc_addr;
  logic [6:0]  dsc_len;
  logic [3:0]  dsc_fbe, dsc_lbe;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rd_req_splitter dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_burst_i(req_burst), .req_be_i(req_be),
    .req_wait_o(req_wait), .req_err_o(req_err),
    .dsc_valid_o(dsc_valid), .dsc_ready_i(dsc_ready), .dsc_addr_o(dsc_addr), .dsc_len_o(dsc_len),
    .dsc_first_be_o(dsc_fbe), .dsc_last_be_o(dsc_lbe), .dsc_fmt64_o(dsc_fmt64),
    .cpl_done_i(cpl_done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic send(input logic [63:0] a, input int bc, input logic [15:0] be);
    while (req_wait) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_burst = 6'(bc); req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_dsc(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (dsc_valid) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic pulse_cpl();
    cpl_done = 1'b1;
    @(negedge clk);
    cpl_done = 1'b0;
  endtask

  task automatic run_single(input logic [63:0] a, input logic [15:0] be, input bit ack);
    logic [3:0] nib [4];
    int lo, hi; bit any, legal, seen;
    logic [63:0] ea;
    any = 0; lo = 0; hi = 0;
    for (int i = 0; i < 4; i++) begin
      nib[i] = be[4*i +: 4];
      if (nib[i] != 0) begin if (!any) lo = i; hi = i; any = 1; end
    end
    legal = any;
    for (int i = lo + 1; i < hi; i++) if (nib[i] != 4'hF) legal = 0;
    send(a, 1, be);
    check(req_err == !legal, "R7 err on single-beat", 64'(req_err), 64'(!legal));
    if (legal) begin
      ea = (a & ~64'hF) + 64'(4 * lo);
      check(req_wait == 1'b1, "R4 wait after accept", 64'(req_wait), 1);
      wait_dsc(seen);
      check(seen, "R8 single descriptor issued", 64'(seen), 1);
      check(dsc_addr == ea, "R8 R12 single addr", dsc_addr, ea);
      check(int'(dsc_len) == hi - lo + 1, "R8 single len", 64'(dsc_len), 64'(hi - lo + 1));
      check(dsc_fbe == nib[lo], "R8 first be", 64'(dsc_fbe), 64'(nib[lo]));
      check(dsc_lbe == ((hi == lo) ? 4'h0 : nib[hi]), "R8 last be", 64'(dsc_lbe),
            64'((hi == lo) ? 4'h0 : nib[hi]));
      check(dsc_fmt64 == (ea[63:32] != 0), "R9 fmt64", 64'(dsc_fmt64), 64'(ea[63:32] != 0));
      if (ack) pulse_cpl(); else @(negedge clk);
    end else begin
      @(negedge clk);
      check(!dsc_valid && !req_wait && !req_err, "R10 no descriptor after error",
            {61'b0, dsc_valid, req_wait, req_err}, 0);
    end
  endtask

  task automatic run_burst(input logic [63:0] a, input int bc, input logic [15:0] be, input bit ack);
    logic [63:0] ca; int rem, c, tb; bit legal, seen;
    legal = (bc >= 1) && (bc <= 32) && ((bc == 1) || (be == 16'hFFFF));
    send(a, bc, be);
    check(req_err == !legal, "R6 R10 err on burst", 64'(req_err), 64'(!legal));
    if (!legal) begin
      @(negedge clk);
      check(!dsc_valid && !req_wait, "R10 no descriptor after error", {62'b0, dsc_valid, req_wait}, 0);
      return;
    end
    ca = a & ~64'hF; rem = bc * 16;
    while (rem > 0) begin
      tb = 4096 - int'(ca[11:0]);
      c = rem; if (tb < c) c = tb; if (256 < c) c = 256;
      wait_dsc(seen);
      check(seen, "R3 chunk issued", 64'(seen), 1);
      check(dsc_addr == ca, "R3 R12 chunk addr", dsc_addr, ca);
      check(int'(dsc_len) == c / 4, "R2 R3 chunk len", 64'(dsc_len), 64'(c / 4));
      check(dsc_fbe == 4'hF && dsc_lbe == 4'hF, "R3 burst be", {56'b0, dsc_fbe, dsc_lbe}, 64'hFF);
      check(dsc_fmt64 == (ca[63:32] != 0), "R9 fmt64", 64'(dsc_fmt64), 64'(ca[63:32] != 0));
      ca += 64'(c); rem -= c;
      if (ack) pulse_cpl(); else @(negedge clk);
    end
    check(!dsc_valid, "R3 no extra chunk", 64'(dsc_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [3:0] opt [5];
    logic [63:0] hold_a;
    bit seen;
    opt[0] = 4'h0; opt[1] = 4'h1; opt[2] = 4'h6; opt[3] = 4'h8; opt[4] = 4'hF;
    repeat (3) @(negedge clk);
    check(!req_wait && !dsc_valid && !req_err, "R1 reset state", {61'b0, req_wait, dsc_valid, req_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req_wait && !dsc_valid && !req_err, "R1 after release", {61'b0, req_wait, dsc_valid, req_err}, 0);

    // R7 R8 single-beat sweep over nibble patterns, varying low address bits
    for (int n = 0; n < 625; n++) begin
      logic [15:0] be;
      int d = n;
      for (int i = 0; i < 4; i++) begin be[4*i +: 4] = opt[d % 5]; d = d / 5; end
      run_single(((n % 2) ? 64'h0000_0001_2345_6780 : 64'h0000_0000_00AB_C000) + 64'(n % 16), be, 1'b1);
    end

    // R3 burst sweep across 4 KB boundaries
    for (int b = 0; b < 2; b++) begin
      for (int o = 0; o < 9; o++) begin
        logic [11:0] offs [9];
        offs[0] = 12'h000; offs[1] = 12'h010; offs[2] = 12'h0F0; offs[3] = 12'h100; offs[4] = 12'hE00;
        offs[5] = 12'hEF0; offs[6] = 12'hF00; offs[7] = 12'hF10; offs[8] = 12'hFF0;
        for (int bc = 1; bc <= 32; bc++)
          run_burst((b ? 64'h0000_0002_0000_3000 : 64'h0000_0000_1000_0000) + 64'(offs[o]) + 64'(bc % 16),
                    bc, 16'hFFFF, 1'b1);
      end
    end

    // R6 R10 illegal requests
    run_burst(64'h1000, 0, 16'hFFFF, 1'b1);
    run_burst(64'h1000, 33, 16'hFFFF, 1'b1);
    run_burst(64'h1000, 2, 16'h0FFF, 1'b1);
    run_burst(64'h1000, 4, 16'hFFF0, 1'b1);

    // R5 slot limit with a stall in the middle of a burst
    for (int i = 0; i < 3; i++) run_burst(64'h10000 + 64'(i * 512), 32, 16'hFFFF, 1'b0);
    run_single(64'h18000, 16'hFFFF, 1'b0);
    send(64'h20000, 32, 16'hFFFF);
    wait_dsc(seen);
    check(seen && dsc_addr == 64'h20000, "R5 first chunk before limit", dsc_addr, 64'h20000);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!dsc_valid && req_wait, "R5 stalled at limit", {62'b0, dsc_valid, req_wait}, 1);
    end
    pulse_cpl();
    wait_dsc(seen);
    check(seen && dsc_addr == 64'h20100, "R5 resume after completion", dsc_addr, 64'h20100);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 64'h30000; req_burst = 6'd1; req_be = 16'hFFFF;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(req_wait && !dsc_valid && !req_err, "R5 port blocked when full",
            {61'b0, req_wait, dsc_valid, req_err}, 64'b100);
    end
    req_valid = 1'b0;
    for (int k = 0; k < 10; k++) pulse_cpl(); // two surplus pulses must be ignored
    for (int i = 0; i < 7; i++) run_single(64'h40000 + 64'(i * 16), 16'h00FF, 1'b0);
    check(!req_wait, "R5 seven slots leave port open", 64'(req_wait), 0);
    run_single(64'h40100, 16'h00FF, 1'b0);
    check(req_wait, "R5 eighth slot closes port", 64'(req_wait), 1);
    for (int k = 0; k < 8; k++) pulse_cpl();
    check(!req_wait, "R5 slots drained", 64'(req_wait), 0);

    // R11 hold under back-pressure
    dsc_ready = 1'b0;
    send(64'h0000_0003_0000_0FF0, 32, 16'hFFFF);
    wait_dsc(seen);
    hold_a = dsc_addr;
    check(hold_a == 64'h0000_0003_0000_0FF0 && dsc_len == 7'd4, "R11 R3 first held chunk",
          hold_a, 64'h0000_0003_0000_0FF0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(dsc_valid && dsc_addr == hold_a && dsc_len == 7'd4, "R11 held stable", dsc_addr, hold_a);
    end
    dsc_ready = 1'b1;
    @(negedge clk);
    check(dsc_valid && dsc_addr == 64'h0000_0003_0000_1000, "R11 next after ready", dsc_addr,
          64'h0000_0003_0000_1000);
    pulse_cpl();
    wait_dsc(seen);
    check(seen && dsc_addr == 64'h0000_0003_0000_1100 && dsc_len == 7'd60, "R3 tail chunk", dsc_addr,
          64'h0000_0003_0000_1100);
    pulse_cpl();
    pulse_cpl();
    summary();
  end
endmodule